// File: doc/BRIEF.md
# Codec Power-Up Configuration Sequencer

This block takes an audio codec from cold power-off to a fully programmed state without software involvement. A single start pulse makes it enable the codec's supply and its audio path, unmute the output, and hold the codec's reset pin low for a fixed settling time. It then releases reset and waits a second settling time for the codec to wake. After that it issues a fixed, ordered list of register writes to a serial control-bus master through a simple byte-burst request port.

The first write puts the codec's internal reset bit high in status register 0. The sequencer then pulses the external reset pin and writes status 0 again with the bit cleared. The normal programming list follows: status 0, status 1, three direct data registers, and six extended registers. Each extended register is sent as a two-byte burst. The sequencer raises a done flag when the bus master acknowledges the final burst.

Each burst carries a command byte made of the codec's 6-bit device address and a 2-bit class. It also carries a length of one or two, and up to two payload bytes. The bus master serialises the burst and answers with a one-cycle done pulse. Both settling delays are derived from the clock frequency, so simulation can shorten them.

Top module: `codec_boot_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a start pulse arrives, the outputs stay at their idle values: pwr_en_o=0, amp_en_o=0, mute_o=1, codec_rst_n_o=0, req_valid_o=0 and done_o=0.
- R2: In the clock cycle after a start is accepted, pwr_en_o=1, amp_en_o=1 and mute_o=0, while codec_rst_n_o stays 0. Power and enable stay high from then on.
- R3: codec_rst_n_o stays low for exactly DLY cycles counted from power-on and then rises, where DLY = (CLK_HZ/1000000)*WAKE_US. The first request appears exactly DLY cycles after that rise.
- R4: The first request is a one-byte status write with payload 0x66. In this payload bit 7 is 0, bit 6 is the codec's reset bit (set), bits 5:4 = 2'b10 select a 256x system clock, bits 3:1 = 3'b011 select 16-bit LSB-justified audio, and bit 0 is 0.
- R5: After the first request is acknowledged, codec_rst_n_o goes low for exactly PULSE cycles, where PULSE = (CLK_HZ/1000000)*PULSE_US, and then returns high. The next request rewrites status 0 with payload 0x26, which has the reset bit cleared. No later request follows a period with codec_rst_n_o low.
- R6: The full write list, in order, is: 0x66, 0x26, 0x26, 0xE0 (status 1: bit 7 set, output and input gain switches at bits 6 and 5), {2'b00,VOLUME}, 0x40 (bass and treble zero), 0xA0, then extended registers 0 through 5.
- R7: Every command byte is {DEV_ADDR, class}. The class is 2'b10 for the first four (status) writes and 2'b00 for all data and extended writes.
- R8: A single-byte request has req_len_o=1 and req_b1_o=0x00. Extended register n (n = 0..5) uses req_len_o=2, req_b0_o=0xC0|n and req_b1_o=0xE0|level, where the levels for n = 0..5 are 4, 4, 3, 0, 0, 0.
- R9: req_valid_o is high for one cycle per request. No new request appears until bus_done_i has acknowledged the previous one.
- R10: done_o rises in the cycle after the acknowledge of the final (13th) request and stays high until the next start.
- R11: A start pulse while a sequence is running has no effect on timing or on the write list. A start pulse while done_o is high restarts the whole sequence from the power-on delay and clears done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| start_i | input | 1 | Start pulse; accepted only when idle or done |
| bus_done_i | input | 1 | One-cycle acknowledge from the serial bus master |
| pwr_en_o | output | 1 | Codec supply enable |
| amp_en_o | output | 1 | Codec audio-path enable |
| mute_o | output | 1 | Output mute, high when muted |
| codec_rst_n_o | output | 1 | Codec reset pin, low = in reset |
| req_valid_o | output | 1 | One-cycle burst request to the bus master |
| req_cmd_o | output | 8 | Command byte {device address, class} |
| req_len_o | output | 2 | Payload length in bytes (1 or 2) |
| req_b0_o | output | 8 | First payload byte |
| req_b1_o | output | 8 | Second payload byte, zero for one-byte bursts |
| done_o | output | 1 | Configuration complete |

## Verification
The power and enable outputs change in the cycle after start is accepted. The reset pin is low for DLY cycles after that and the first request follows DLY cycles later. The reset pulse after the first acknowledge lasts PULSE cycles, and done_o rises one cycle after the last acknowledge. The bench drives inputs and samples outputs on the falling edge, so each of these results is read half a period after the rising edge that produced it. It counts falling edges between events rather than waiting for conditions, so an early or late transition of one cycle changes the count. A responder model acknowledges each request after a programmable latency and logs every request. It also logs how many low-reset cycles preceded the request and whether any request came while one was outstanding. The ordered list and the timing are then compared against values the bench computes on its own.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

  localparam int unsigned NUM_WR    = 13;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned LAST_IDX  = NUM_WR - 1;

  localparam logic [1:0] CLS_STATUS = 2'b10;
  localparam logic [1:0] CLS_DATA   = 2'b00;
  localparam logic [1:0] SYSCLK_256 = 2'b10;
  localparam logic [2:0] FMT_LSB16  = 3'b011;

  typedef struct packed {
    logic [7:0] cmd;
    logic [1:0] len;
    logic [7:0] b0;
    logic [7:0] b1;
  } wr_entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_POWER,
    S_WAKE,
    S_ISSUE,
    S_WAIT,
    S_PULSE,
    S_DONE
  } seq_state_t;

  // Clock cycles in a delay given in microseconds.
  function automatic int unsigned cycles_for(input int unsigned hz, input int unsigned us);
    int unsigned c;
    c = (hz / 1000000) * us;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic logic [7:0] status0_byte(input logic rst_bit);
    return {1'b0, rst_bit, SYSCLK_256, FMT_LSB16, 1'b0};
  endfunction

  function automatic logic [4:0] ext_level(input logic [2:0] n);
    case (n)
      3'd0, 3'd1: return 5'd4;
      3'd2:       return 5'd3;
      default:    return 5'd0;
    endcase
  endfunction

  // Entry k of the ordered programming list.
  function automatic wr_entry_t make_entry(input logic [IDX_W-1:0] k,
                                           input logic [5:0] dev,
                                           input logic [5:0] vol);
    wr_entry_t e;
    logic [2:0] n;
    n    = 3'(k - IDX_W'(7));
    e.b1 = 8'h00;
    e.len = 2'd1;
    case (k)
      4'd0: begin e.cmd = {dev, CLS_STATUS}; e.b0 = status0_byte(1'b1); end
      4'd1,
      4'd2: begin e.cmd = {dev, CLS_STATUS}; e.b0 = status0_byte(1'b0); end
      4'd3: begin e.cmd = {dev, CLS_STATUS}; e.b0 = {1'b1, 1'b1, 1'b1, 5'd0}; end
      4'd4: begin e.cmd = {dev, CLS_DATA};   e.b0 = {2'b00, vol}; end
      4'd5: begin e.cmd = {dev, CLS_DATA};   e.b0 = {2'b01, 4'd0, 2'd0}; end
      4'd6: begin e.cmd = {dev, CLS_DATA};   e.b0 = {2'b10, 1'b1, 5'd0}; end
      default: begin
        e.cmd = {dev, CLS_DATA};
        e.len = 2'd2;
        e.b0  = {2'b11, 3'b000, n};
        e.b1  = {3'b111, ext_level(n)};
      end
    endcase
    return e;
  endfunction

endpackage

// File: rtl/codec_seq_timer.sv
module codec_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  assign expire = run && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || expire) cnt <= '0;
    else                     cnt <= cnt + CNT_W'(1);
  end

  // R3: a running count never passes its limit
  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit));

endmodule

// File: rtl/codec_seq_wrlist.sv
module codec_seq_wrlist
  import codec_seq_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR = 6'h05,
  parameter logic [5:0] VOLUME   = 6'h0A
) (
  input  logic [IDX_W-1:0] idx_i,
  output wr_entry_t        entry_o
);

  wr_entry_t tbl [NUM_WR];

  for (genvar g = 0; g < NUM_WR; g++) begin : g_entry
    assign tbl[g] = make_entry(IDX_W'(g), DEV_ADDR, VOLUME);
  end

  assign entry_o = (idx_i < IDX_W'(NUM_WR)) ? tbl[idx_i] : '0;

endmodule

// File: rtl/codec_boot_seq.sv
module codec_boot_seq
  import codec_seq_pkg::*;
#(
  parameter logic [5:0]  DEV_ADDR = 6'h05,
  parameter logic [5:0]  VOLUME   = 6'h0A,
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned WAKE_US  = 100_000,
  parameter int unsigned PULSE_US = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       bus_done_i,
  output logic       pwr_en_o,
  output logic       amp_en_o,
  output logic       mute_o,
  output logic       codec_rst_n_o,
  output logic       req_valid_o,
  output logic [7:0] req_cmd_o,
  output logic [1:0] req_len_o,
  output logic [7:0] req_b0_o,
  output logic [7:0] req_b1_o,
  output logic       done_o
);

  localparam int unsigned DLY_CYC   = cycles_for(CLK_HZ, WAKE_US);
  localparam int unsigned PULSE_CYC = cycles_for(CLK_HZ, PULSE_US);
  localparam int unsigned MAX_CYC   = (DLY_CYC > PULSE_CYC) ? DLY_CYC : PULSE_CYC;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  seq_state_t       state, state_nx;
  logic [IDX_W-1:0] idx, idx_nx;
  wr_entry_t        entry;
  logic             tmr_run, tmr_expire;
  logic [CNT_W-1:0] tmr_limit;

  // Named internal events
  logic ev_start_accept, ev_write_ack, ev_pulse_begin, ev_last_ack;

  assign ev_start_accept = start_i && (state == S_IDLE || state == S_DONE);
  assign ev_write_ack    = (state == S_WAIT) && bus_done_i;
  assign ev_pulse_begin  = ev_write_ack && (idx == '0);
  assign ev_last_ack     = ev_write_ack && (idx == IDX_W'(LAST_IDX));

  assign tmr_run   = (state == S_POWER) || (state == S_WAKE) || (state == S_PULSE);
  assign tmr_limit = (state == S_PULSE) ? CNT_W'(PULSE_CYC) : CNT_W'(DLY_CYC);

  codec_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (tmr_run),
    .limit  (tmr_limit),
    .expire (tmr_expire)
  );

  codec_seq_wrlist #(.DEV_ADDR(DEV_ADDR), .VOLUME(VOLUME)) u_list (
    .idx_i   (idx),
    .entry_o (entry)
  );

  always_comb begin
    state_nx = state;
    idx_nx   = idx;
    case (state)
      S_IDLE, S_DONE: if (ev_start_accept) begin
        state_nx = S_POWER;
        idx_nx   = '0;
      end
      S_POWER: if (tmr_expire) state_nx = S_WAKE;
      S_WAKE:  if (tmr_expire) state_nx = S_ISSUE;
      S_ISSUE: state_nx = S_WAIT;
      S_WAIT: begin
        if (ev_pulse_begin)   state_nx = S_PULSE;
        else if (ev_last_ack) state_nx = S_DONE;
        else if (ev_write_ack) begin
          state_nx = S_ISSUE;
          idx_nx   = idx + IDX_W'(1);
        end
      end
      S_PULSE: if (tmr_expire) begin
        state_nx = S_ISSUE;
        idx_nx   = IDX_W'(1);
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
    end else begin
      state <= state_nx;
      idx   <= idx_nx;
    end
  end

  assign pwr_en_o      = (state != S_IDLE);
  assign amp_en_o      = (state != S_IDLE);
  assign mute_o        = (state == S_IDLE);
  assign codec_rst_n_o = (state == S_WAKE) || (state == S_ISSUE) ||
                         (state == S_WAIT) || (state == S_DONE);
  assign req_valid_o   = (state == S_ISSUE);
  assign done_o        = (state == S_DONE);
  assign req_cmd_o     = entry.cmd;
  assign req_len_o     = entry.len;
  assign req_b0_o      = entry.b0;
  assign req_b1_o      = entry.b1;

  // R2: power, once on, stays on
  a_r2_power_holds: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en_o |=> pwr_en_o);

  // R2: a fresh start turns power on with the codec still in reset
  a_r2_start_powers: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start_accept && !pwr_en_o) |=> (pwr_en_o && !mute_o && !codec_rst_n_o));

  // R3: codec reset is only released while powered and unmuted
  a_r3_release_powered: assert property (@(posedge clk) disable iff (!rst_n)
    codec_rst_n_o |-> (pwr_en_o && amp_en_o && !mute_o));

  // R5: acknowledge of the first write pulls the reset pin low
  a_r5_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pulse_begin |=> !codec_rst_n_o);

  // R5: requests are only issued with the codec out of reset
  a_r5_req_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> codec_rst_n_o);

  // R7: every command carries the device address
  a_r7_dev_addr: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_cmd_o[7:2] == DEV_ADDR));

  // R8: burst length is one or two, second byte zero for one-byte bursts
  a_r8_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> ((req_len_o == 2'd2) || (req_len_o == 2'd1 && req_b1_o == 8'h00)));

  // R9: a request lasts one cycle
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |=> !req_valid_o);

  // R10: done follows the final acknowledge and holds without start
  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_ack |=> done_o);

  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

endmodule

// File: tb/sim_codec_boot_seq.sv
module sim_codec_boot_seq;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned CLK_HZ   = 1_000_000;
  localparam int unsigned WAKE_US  = 12;
  localparam int unsigned PULSE_US = 3;
  localparam int DLY   = 12;
  localparam int PULSE = 3;
  localparam logic [5:0] DEV = 6'h05;
  localparam logic [5:0] VOL = 6'h0A;
  localparam int NREC = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic bus_done = 1'b0;
  logic pwr_en, amp_en, mute, codec_rst_n, req_valid, done;
  logic [7:0] req_cmd, req_b0, req_b1;
  logic [1:0] req_len;

  int n_chk = 0;
  int n_bad = 0;

  // responder state and log
  int lat = 2;
  int rec_n = 0;
  int low_acc = 0;
  int overlap = 0;
  logic [7:0] r_cmd [32];
  logic [1:0] r_len [32];
  logic [7:0] r_b0  [32];
  logic [7:0] r_b1  [32];
  int         r_low [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_boot_seq #(
    .DEV_ADDR(DEV), .VOLUME(VOL), .CLK_HZ(CLK_HZ),
    .WAKE_US(WAKE_US), .PULSE_US(PULSE_US)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bus_done_i(bus_done),
    .pwr_en_o(pwr_en), .amp_en_o(amp_en), .mute_o(mute),
    .codec_rst_n_o(codec_rst_n), .req_valid_o(req_valid),
    .req_cmd_o(req_cmd), .req_len_o(req_len), .req_b0_o(req_b0),
    .req_b1_o(req_b1), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Bus master model: logs each request and acknowledges after lat cycles.
  initial begin
    bit busy = 0;
    int left = 0;
    forever begin
      @(negedge clk);
      bus_done = 1'b0;
      if (!codec_rst_n) low_acc++;
      if (busy) begin
        if (req_valid) overlap++;
        if (left == 0) begin bus_done = 1'b1; busy = 0; end
        else left--;
      end else if (req_valid) begin
        if (rec_n < 32) begin
          r_cmd[rec_n] = req_cmd; r_len[rec_n] = req_len;
          r_b0[rec_n] = req_b0;   r_b1[rec_n] = req_b1;
          r_low[rec_n] = low_acc;
        end
        low_acc = 0;
        rec_n++;
        busy = 1;
        left = lat - 1;
      end
    end
  end

  function automatic logic [7:0] exp_cmd(input int k);
    return (k < 4) ? {DEV, 2'b10} : {DEV, 2'b00};
  endfunction
  function automatic logic [1:0] exp_len(input int k);
    return (k >= 7) ? 2'd2 : 2'd1;
  endfunction
  function automatic logic [7:0] exp_b0(input int k);
    case (k)
      0: return 8'h66;
      1, 2: return 8'h26;
      3: return 8'hE0;
      4: return {2'b00, VOL};
      5: return 8'h40;
      6: return 8'hA0;
      default: return 8'hC0 + 8'(k - 7);
    endcase
  endfunction
  function automatic logic [7:0] exp_b1(input int k);
    case (k)
      7, 8: return 8'hE4;
      9: return 8'hE3;
      10, 11, 12: return 8'hE0;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_log(input string tag);
    check(rec_n == NREC, {"R6 count ", tag}, rec_n, NREC);
    for (int k = 0; k < NREC; k++) begin
      check(r_cmd[k] == exp_cmd(k), (k < 4) ? "R7 status class" : "R7 data class", r_cmd[k], exp_cmd(k));
      check(r_len[k] == exp_len(k), "R8 length", r_len[k], exp_len(k));
      check(r_b0[k] == exp_b0(k), (k == 0) ? "R4 first payload" : "R6 payload", r_b0[k], exp_b0(k));
      check(r_b1[k] == exp_b1(k), "R8 second byte", r_b1[k], exp_b1(k));
    end
    check(r_low[1] == PULSE, "R5 reset pulse width", r_low[1], PULSE);
    for (int k = 2; k < NREC; k++)
      check(r_low[k] == 0, "R5 no later reset", r_low[k], 0);
    check(overlap == 0, "R9 request while outstanding", overlap, 0);
  endtask

  task automatic check_idle(input string tag);
    check(!pwr_en && !amp_en, {"R1 power off ", tag}, {pwr_en, amp_en}, 0);
    check(mute, {"R1 muted ", tag}, mute, 1);
    check(!codec_rst_n, {"R1 codec in reset ", tag}, codec_rst_n, 0);
    check(!req_valid && !done, {"R1 no request/done ", tag}, {req_valid, done}, 0);
  endtask

  task automatic t_reset_idle();
    repeat (3) @(negedge clk);
    check_idle("in reset");
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check_idle("idle");
    check(rec_n == 0, "R1 no request in idle", rec_n, 0);
  endtask

  // One boot run; inject start pulses mid-run when busy_start is set.
  task automatic t_boot(input int latency, input bit busy_start, input string tag);
    int n;
    int m;
    int w;
    bit injected;
    lat = latency;
    rec_n = 0;
    low_acc = 0;
    overlap = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(pwr_en && amp_en, {"R2 power on ", tag}, {pwr_en, amp_en}, 3);
    check(!mute, {"R2 unmuted ", tag}, mute, 0);
    check(!codec_rst_n, {"R2 reset held ", tag}, codec_rst_n, 0);
    check(!done, {"R11 done cleared ", tag}, done, 0);
    n = 0;
    while (!codec_rst_n && n < 1000) begin
      n++;
      start = (busy_start && n == 3) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(n == DLY, {"R3 reset low time ", tag}, n, DLY);
    m = 0;
    while (!req_valid && m < 1000) begin m++; @(negedge clk); end
    check(m == DLY, {"R3 wake to first request ", tag}, m, DLY);
    w = 0;
    injected = 0;
    while (!done && w < 5000) begin
      w++;
      if (busy_start && !injected && rec_n == 5) begin start = 1'b1; injected = 1; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(done, {"R10 done reached ", tag}, done, 1);
    check(!bus_done, {"R10 done after last ack ", tag}, bus_done, 0);
    check_log(tag);
    repeat (15) @(negedge clk);
    check(done && pwr_en && codec_rst_n, {"R10 done holds ", tag}, {done, pwr_en, codec_rst_n}, 7);
    check(rec_n == NREC, {"R10 no extra request ", tag}, rec_n, NREC);
  endtask

  initial begin
    t_reset_idle();
    t_boot(2, 1'b0, "first");
    t_boot(6, 1'b1, "restart with busy starts (R11)");
    t_boot(1, 1'b0, "min latency");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule